// File: doc/BRIEF.md
# Multi-Lane Addressable LED Waveform Generator

This block drives many single-wire addressable LED strings at once from one shared bit-plane store. Each stored word stands for one bit period and carries one bit for each output lane. Every bit period has three fixed edges that all lanes share: all enabled lanes rise together, the lanes whose bit is 0 fall a short time later, and every lane is low from a later point until the period ends. Because the edges are common, any number of lanes move in lockstep and only one word is read per bit period.

A frame starts with a one-cycle start request. The block samples the LED count and the lane-enable mask at that moment. It sends one quiet bit period and then 24 data periods per LED, reading the word for the next period from a synchronous memory port while the current period is on the wire. After the last period all lines stay low for a guard interval of at least 50 µs. A done flag then rises and stays high until the next frame is accepted. Start requests that arrive while a frame or its guard interval is running are ignored.

Top module: `ledwave_engine`

## Requirements
- R1: A bit period lasts 60 clock cycles. Each enabled lane goes high on the first cycle of every data period.
- R2: A lane whose bit is 0 in the period's word goes low 12 cycles into the period. A lane whose bit is 1 stays high until cycle 31. Bit i of the word belongs to lane_o[i].
- R3: From cycle 31 of a data period to its end, every lane is low.
- R4: A lane whose bit is clear in the mask sampled at start stays low for the whole frame. Changes to lane_en_i after the start have no effect on that frame.
- R5: While reset is active and right after it, lane_o is all zero and done_o, busy_o and rd_en_o are low.
- R6: For a nonzero LED count N, exactly 24·N reads are issued, at addresses 0, 1, 2, … in order, one per period, on the first cycle of the period before the one that uses the word. Read data is taken one cycle after rd_en_o.
- R7: A quiet period of 60 cycles with all lanes low comes before the first data period.
- R8: After the last data period all lanes stay low for 2640 cycles. Then busy_o falls and done_o rises. With N nonzero this happens (N·24+1)·60+2640 cycles after the start is accepted.
- R9: A start request while busy_o is high is ignored. The running frame's count, mask and waveform stay as they were.
- R10: A start with an LED count of zero issues no reads and no pulses. It raises done_o 2640 cycles after acceptance.
- R11: done_o clears on the cycle after a start is accepted. A start held high across the end of the guard interval is accepted on the first cycle after done_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-timing clock (48 MHz for the default timing) |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to send a frame; acted on only while idle |
| led_count_i | input | CNT_W | Number of LEDs in the frame, sampled at start |
| lane_en_i | input | LANES | Lane enable mask, sampled at start |
| rd_en_o | output | 1 | Read strobe to the bit-plane memory |
| rd_addr_o | output | ADDR_W | Bit-period index to read |
| rd_data_i | input | LANES | Read word, valid one cycle after rd_en_o |
| lane_o | output | LANES | Serial LED data lines |
| busy_o | output | 1 | Frame or guard interval in progress |
| done_o | output | 1 | Last frame finished; held until the next start |

## Verification
The hard case is the end of a guard interval meeting a new start request in the same cycle. In that cycle the state is still counting the guard, so the request must be refused, and it must be taken one cycle later. The bench raises start three cycles before the predicted end of the guard and holds it. It then requires done_o to be high for exactly one sampled cycle and the next frame to begin on the following edge. A second case puts a start request and a mask change in the middle of a data period. The bench checks that the lane waveform, the read sequence and the read count of the running frame are unchanged.

// File: rtl/ledwave_pkg.sv
package ledwave_pkg;

    localparam int BITS_PER_LED = 24;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_DATA  = 2'd2,
        ST_GUARD = 2'd3
    } wave_state_e;

endpackage

// File: rtl/ledwave_timer.sv
module ledwave_timer #(
    parameter int SLOT_CYC  = 60,
    parameter int GUARD_CYC = 2640,
    parameter int CYC_W     = $clog2(SLOT_CYC),
    parameter int GRD_W     = $clog2(GUARD_CYC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_run_i,
    input  logic             guard_run_i,
    output logic [CYC_W-1:0] cyc_o,
    output logic             slot_last_o,
    output logic [GRD_W-1:0] gcnt_o,
    output logic             guard_last_o
);

    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(SLOT_CYC - 1);
    localparam logic [GRD_W-1:0] GRD_LAST = GRD_W'(GUARD_CYC - 1);

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        logic [GRD_W-1:0] gcnt;
    } timer_t;

    timer_t tm_d, tm_q;

    assign cyc_o        = tm_q.cyc;
    assign gcnt_o       = tm_q.gcnt;
    assign slot_last_o  = (tm_q.cyc == CYC_LAST);
    assign guard_last_o = (tm_q.gcnt == GRD_LAST);

    always_comb begin
        tm_d = tm_q;
        if (slot_run_i) begin
            tm_d.cyc = slot_last_o ? '0 : tm_q.cyc + 1'b1;
        end else begin
            tm_d.cyc = '0;
        end
        if (guard_run_i) begin
            tm_d.gcnt = tm_q.gcnt + 1'b1;
        end else begin
            tm_d.gcnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    // R1: a period only restarts after its final cycle
    assert_slot_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_run_i && $past(slot_run_i) && tm_q.cyc == '0) |-> $past(tm_q.cyc) == CYC_LAST);

endmodule

// File: rtl/ledwave_fetch.sv
module ledwave_fetch #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              issue_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [LANES-1:0]  rd_data_i,
    output logic [LANES-1:0]  word_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              pend;
        logic [LANES-1:0]  word;
    } fetch_t;

    fetch_t fe_d, fe_q;

    assign rd_en_o   = issue_i;
    assign rd_addr_o = fe_q.addr;
    assign word_o    = fe_q.word;

    always_comb begin
        fe_d      = fe_q;
        fe_d.pend = issue_i;
        if (clear_i) begin
            fe_d.addr = '0;
        end else if (issue_i) begin
            fe_d.addr = fe_q.addr + 1'b1;
        end
        if (fe_q.pend) begin
            fe_d.word = rd_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fe_q <= '0;
        end else begin
            fe_q <= fe_d;
        end
    end

    // R6: never two reads back to back
    assert_one_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> !rd_en_o);

    // R6: the word is taken one cycle after the read strobe
    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fe_q.pend |=> word_o == $past(rd_data_i));

endmodule

// File: rtl/ledwave_shaper.sv
module ledwave_shaper #(
    parameter int LANES  = 32,
    parameter int CYC_W  = 6,
    parameter int T0_CYC = 12,
    parameter int T1_CYC = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [CYC_W-1:0] cyc_i,
    input  logic [LANES-1:0] word_i,
    input  logic [LANES-1:0] mask_i,
    output logic [LANES-1:0] lane_o
);

    localparam logic [CYC_W-1:0] T0_V = CYC_W'(T0_CYC);
    localparam logic [CYC_W-1:0] T1_V = CYC_W'(T1_CYC);

    typedef struct packed {
        logic [LANES-1:0] lane;
    } shape_t;

    shape_t sh_d, sh_q;

    assign lane_o = sh_q.lane;

    always_comb begin
        sh_d = sh_q;
        if (!active_i || cyc_i >= T1_V) begin
            sh_d.lane = '0;
        end else if (cyc_i < T0_V) begin
            sh_d.lane = mask_i;
        end else begin
            sh_d.lane = mask_i & word_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    // R4: a masked-off lane never shows a high level
    assert_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_o & ~mask_i) == '0);

    // R1: rising edges only come from the first cycle of a data period
    assert_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_o & ~$past(lane_o)) != '0) |-> ($past(cyc_i) == '0 && $past(active_i)));

    // R2: falling edges only at one of the two fall points
    assert_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((~lane_o & $past(lane_o)) != '0) |-> ($past(cyc_i) == T0_V || $past(cyc_i) == T1_V));

    // R3: tail of each period is low
    assert_tail_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cyc_i) >= T1_V) |-> lane_o == '0);

endmodule

// File: rtl/ledwave_engine.sv
module ledwave_engine #(
    parameter int LANES     = 32,
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = CNT_W + 5,
    parameter int SLOT_CYC  = 60,
    parameter int T0_CYC    = 12,
    parameter int T1_CYC    = 31,
    parameter int GUARD_CYC = 2640
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  led_count_i,
    input  logic [LANES-1:0]  lane_en_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [LANES-1:0]  rd_data_i,
    output logic [LANES-1:0]  lane_o,
    output logic              busy_o,
    output logic              done_o
);
    import ledwave_pkg::*;

    localparam int CYC_W = $clog2(SLOT_CYC);
    localparam int GRD_W = $clog2(GUARD_CYC);
    localparam logic [GRD_W-1:0] GRD_LAST = GRD_W'(GUARD_CYC - 1);

    typedef struct packed {
        wave_state_e       state;
        logic [LANES-1:0]  mask;
        logic [ADDR_W-1:0] total;
        logic [ADDR_W-1:0] idx;
        logic [LANES-1:0]  word;
        logic              done;
    } eng_t;

    eng_t en_d, en_q;

    logic [CYC_W-1:0] cyc;
    logic [GRD_W-1:0] gcnt;
    logic             slot_last;
    logic             guard_last;
    logic [LANES-1:0] next_word;
    logic             accept;
    logic             issue;
    logic             last_idx;

    assign accept   = (en_q.state == ST_IDLE) && start_i;
    assign last_idx = (en_q.idx == en_q.total - 1'b1);
    assign issue    = (cyc == '0) &&
                      ((en_q.state == ST_LEAD) || (en_q.state == ST_DATA && !last_idx));
    assign busy_o   = (en_q.state != ST_IDLE);
    assign done_o   = en_q.done;

    ledwave_timer #(
        .SLOT_CYC (SLOT_CYC),
        .GUARD_CYC(GUARD_CYC),
        .CYC_W    (CYC_W),
        .GRD_W    (GRD_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_run_i  ((en_q.state == ST_LEAD) || (en_q.state == ST_DATA)),
        .guard_run_i (en_q.state == ST_GUARD),
        .cyc_o       (cyc),
        .slot_last_o (slot_last),
        .gcnt_o      (gcnt),
        .guard_last_o(guard_last)
    );

    ledwave_fetch #(
        .LANES (LANES),
        .ADDR_W(ADDR_W)
    ) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .issue_i  (issue),
        .rd_en_o  (rd_en_o),
        .rd_addr_o(rd_addr_o),
        .rd_data_i(rd_data_i),
        .word_o   (next_word)
    );

    ledwave_shaper #(
        .LANES (LANES),
        .CYC_W (CYC_W),
        .T0_CYC(T0_CYC),
        .T1_CYC(T1_CYC)
    ) u_shaper (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(en_q.state == ST_DATA),
        .cyc_i   (cyc),
        .word_i  (en_q.word),
        .mask_i  (en_q.mask),
        .lane_o  (lane_o)
    );

    always_comb begin
        en_d = en_q;
        unique case (en_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    en_d.mask  = lane_en_i;
                    en_d.total = ADDR_W'(led_count_i) * ADDR_W'(BITS_PER_LED);
                    en_d.idx   = '0;
                    en_d.done  = 1'b0;
                    en_d.state = (led_count_i == '0) ? ST_GUARD : ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (slot_last) begin
                    en_d.word  = next_word;
                    en_d.idx   = '0;
                    en_d.state = ST_DATA;
                end
            end
            ST_DATA: begin
                if (slot_last) begin
                    if (last_idx) begin
                        en_d.state = ST_GUARD;
                    end else begin
                        en_d.idx  = en_q.idx + 1'b1;
                        en_d.word = next_word;
                    end
                end
            end
            ST_GUARD: begin
                if (guard_last) begin
                    en_d.state = ST_IDLE;
                    en_d.done  = 1'b1;
                end
            end
            default: en_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= '0;
            en_q.state <= ST_IDLE;
        end else begin
            en_q <= en_d;
        end
    end

    // R7: the leading period stays quiet
    assert_lead_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q.state == ST_LEAD && $past(en_q.state) == ST_LEAD) |-> lane_o == '0);

    // R8: done only after a full guard interval
    assert_done_after_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(en_q.state) == ST_GUARD && $past(gcnt) == GRD_LAST));

    // R8: lines stay low through the guard interval
    assert_guard_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q.state == ST_GUARD && $past(en_q.state) == ST_GUARD) |-> lane_o == '0);

    // R9: a busy start leaves the latched mask alone
    assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> en_q.mask == $past(en_q.mask));

    // R10: an empty frame jumps to the guard interval
    assert_empty_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && led_count_i == '0) |=> (en_q.state == ST_GUARD && !rd_en_o));

    // R11: an accepted start clears done
    assert_done_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!done_o && busy_o));

endmodule

// File: tb/ledwave_engine_test.sv
`timescale 1ns/1ps
module ledwave_engine_test;

    localparam int LANES  = 32;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = CNT_W + 5;
    localparam int SLOT   = 60;
    localparam int GUARD  = 2640;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start_i;
    logic [CNT_W-1:0]  led_count_i;
    logic [LANES-1:0]  lane_en_i;
    logic              rd_en_o;
    logic [ADDR_W-1:0] rd_addr_o;
    logic [LANES-1:0]  rd_data_i = '0;
    logic [LANES-1:0]  lane_o;
    logic              busy_o;
    logic              done_o;

    int checks = 0;
    int errors = 0;
    int reads_seen = 0;

    typedef struct {
        logic [LANES-1:0] lanes;
        logic [LANES-1:0] mask;
        int               lane_tag;
        logic             done;
        logic             busy;
        int               state_tag;
        logic             rd;
        int               addr;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    ledwave_engine uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .led_count_i(led_count_i),
        .lane_en_i  (lane_en_i),
        .rd_en_o    (rd_en_o),
        .rd_addr_o  (rd_addr_o),
        .rd_data_i  (rd_data_i),
        .lane_o     (lane_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    function automatic logic [LANES-1:0] mem_word(int k);
        logic [31:0] v;
        v = (32'h9E3779B9 * 32'(k + 1)) ^ (32'(k) << 11);
        return v;
    endfunction

    // bit-plane memory model: one cycle read latency
    always @(posedge clk) begin
        if (rd_en_o) rd_data_i <= mem_word(int'(rd_addr_o));
    end

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic string tag_name(int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            7: return "R7";
            8: return "R8";
            10: return "R10";
            11: return "R11";
            default: return "R4";
        endcase
    endfunction

    // monitor: pops one expected item per cycle and compares
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(lane_o === e.lanes, tag_name(e.lane_tag), "lane_o", 64'(lane_o), 64'(e.lanes));
            check((lane_o & ~e.mask) == '0, "R4", "masked lanes", 64'(lane_o), 64'(lane_o & e.mask));
            check(done_o === e.done, tag_name(e.state_tag), "done_o", 64'(done_o), 64'(e.done));
            check(busy_o === e.busy, tag_name(e.state_tag), "busy_o", 64'(busy_o), 64'(e.busy));
            check(rd_en_o === e.rd, "R6", "rd_en_o", 64'(rd_en_o), 64'(e.rd));
            if (e.rd) begin
                check(int'(rd_addr_o) == e.addr, "R6", "rd_addr_o", 64'(rd_addr_o), 64'(e.addr));
            end
            if (rd_en_o) reads_seen++;
        end
    end

    // driver: pushes the expected waveform of one frame, then paces it
    task automatic run_frame(int cnt, logic [LANES-1:0] msk, bit pre, bit inj, bit arm,
                             int ncnt, logic [LANES-1:0] nmsk);
        int s_tot;
        int td;
        int err0;
        s_tot = cnt * 24;
        td = (s_tot == 0) ? GUARD : SLOT * (s_tot + 1) + GUARD;
        if (!pre) begin
            @(negedge clk);
            led_count_i = CNT_W'(cnt);
            lane_en_i   = msk;
            start_i     = 1'b1;
        end
        @(posedge clk);
        reads_seen = 0;
        err0 = errors;
        for (int n = 0; n <= td; n++) begin
            exp_t e;
            int j;
            e.mask = msk;
            e.lanes = '0;
            e.lane_tag = (s_tot == 0) ? 10 : 7;
            j = n - 61;
            if (s_tot > 0 && j >= 0) begin
                int s;
                int c;
                s = j / SLOT;
                c = j % SLOT;
                if (s < s_tot) begin
                    if (c < 12) begin
                        e.lanes = msk; e.lane_tag = 1;
                    end else if (c < 31) begin
                        e.lanes = msk & mem_word(s); e.lane_tag = 2;
                    end else begin
                        e.lane_tag = 3;
                    end
                end else begin
                    e.lane_tag = 8;
                end
            end
            e.done = (n >= td);
            e.busy = (n < td);
            e.state_tag = (n == 0) ? 11 : ((s_tot == 0) ? 10 : 8);
            e.rd = (n % SLOT == 0) && (n / SLOT < s_tot);
            e.addr = n / SLOT;
            exp_q.push_back(e);
        end
        for (int n = 0; n <= td; n++) begin
            @(negedge clk);
            if (n == 0) start_i = 1'b0;
            if (inj && n == 1000) begin
                start_i     = 1'b1;
                lane_en_i   = ~msk;
                led_count_i = CNT_W'(5);
            end
            if (inj && n == 1001) start_i = 1'b0;
            if (arm && n == td - 3) begin
                start_i     = 1'b1;
                led_count_i = CNT_W'(ncnt);
                lane_en_i   = nmsk;
            end
        end
        check(reads_seen == s_tot, (s_tot == 0) ? "R10" : "R6", "read count",
              64'(reads_seen), 64'(s_tot));
        if (inj) begin
            check(errors == err0, "R9", "frame disturbed by busy start",
                  64'(errors - err0), 64'(0));
        end
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL R8 watchdog: actual still running, expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        start_i     = 1'b0;
        led_count_i = '0;
        lane_en_i   = '1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(lane_o == '0, "R5", "lane_o in reset", 64'(lane_o), 64'(0));
        check(!done_o && !busy_o && !rd_en_o, "R5", "flags in reset",
              64'({done_o, busy_o, rd_en_o}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(lane_o == '0, "R5", "lane_o after reset", 64'(lane_o), 64'(0));
        check(!done_o && !busy_o && !rd_en_o, "R5", "flags after reset",
              64'({done_o, busy_o, rd_en_o}), 64'(0));

        run_frame(1, 32'hFFFF_FFFF, 0, 0, 0, 0, '0);
        run_frame(2, 32'hA5C3_0F81, 0, 1, 1, 0, 32'h3333_CCCC);
        run_frame(0, 32'h3333_CCCC, 1, 0, 0, 0, '0);
        run_frame(1, 32'h0000_0000, 0, 0, 0, 0, '0);
        run_frame(3, 32'h7FFF_FFFE, 0, 0, 0, 0, '0);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule